// File: doc/BRIEF.md
# Watchdog Timer with Keyed Feed Sequence

This block supervises software. A 32-bit counter counts down at a quarter of the bus clock rate. If software does not reload it in time, the block either requests a system reset or raises an interrupt. Software reloads the counter with a two-write key sequence sent to a feed register. A key sequence that is broken or wrong is also treated as a fault, with the same response as a timeout.

Software enables the watchdog, and also chooses reset over interrupt, by writing ones to a control register. Neither bit can be cleared by software. Both are cleared by a hardware reset or by the block's own timeout or fault event. After it is enabled, the counter stays idle until the first valid feed. A debug-halt input freezes the countdown while a debugger has the processor stopped. A sticky flag shows that the block's own reset request fired. This flag survives the system reset that the request causes, and only a hardware reset or software can clear it.

The register bus has single-cycle accesses, and read data is combinational. There are four word registers:
- address 0: control and status.
- address 1: reload value.
- address 2: feed register, which reads as zero.
- address 3: live count, read-only.

Top module: `wdt_sentinel`

## Requirements
- R1: After hardware reset the control register (address 0) reads 0, the count (address 3) reads 0, the reload register (address 1) reads the parameter RELOAD_RST, and both rst_req_o and irq_o are low.
- R2: Writing a one to control bit 0 (enable) or to control bit 1 (reset select) sets that bit. Writing zeros never clears either bit.
- R3: The counter holds its value while the block is not running. Running (control bit 4) starts only at a valid feed made while enable is set. A valid feed made while disabled has no effect.
- R4: A valid feed is a bus write of 0xAA to address 2, with the very next bus access being a write of 0x55 to address 2. While enabled, a valid feed loads the count with the reload value and restarts the prescaler.
- R5: While running, the count decrements once every 4 clock cycles. The first decrement lands 4 cycles after the load.
- R6: With reset select set, a prescaled tick that finds the count at 0 produces a one-cycle pulse on rst_req_o and sets control bit 3. It also clears enable, reset select and running.
- R7: With reset select clear, the same timeout raises irq_o and sets control bit 2, and clears enable and running. irq_o stays high until software writes a one to control bit 2.
- R8: While running, a bad feed causes the same response as a timeout, in either mode. A bad feed is a write to address 2 of any value other than 0xAA that does not complete a pair, or any access other than the 0x55 write that directly follows 0xAA.
- R9: While not running, a bad feed has no effect on outputs or registers.
- R10: While dbg_halt_i is high, both the count and the prescaler are frozen.
- R11: Writing a one to control bit 3 clears it, and a hardware reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high hardware reset |
| bus_sel_i | input | 1 | Bus access in this cycle |
| bus_wr_i | input | 1 | Access is a write |
| bus_addr_i | input | 2 | Word register address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (zero when not selected) |
| dbg_halt_i | input | 1 | Debug halt: freeze countdown |
| rst_req_o | output | 1 | One-cycle reset request |
| irq_o | output | 1 | Level interrupt on timeout or fault |

## Verification
The hardest case to reach is a fault that lands exactly on the sequence boundary: a legal 0xAA write followed at once by some other access, made while the counter is running. The fault must be told apart from a timeout and from a harmless slip while idle. The stimulus arms the block with a long reload, feeds it, and then inserts a reload write right after 0xAA, so the fault comes long before any timeout. The same broken pair is repeated while the block is not running, where it must do nothing. A behavioural model tracks key state, prescaler phase and count on every clock, so a tick or fault placed one cycle early or late shows up as a mismatch.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int ADDR_W = 2;
    localparam int DATA_W = 32;

    // Feed keys, compared against the full write word
    localparam logic [DATA_W-1:0] KEY_FIRST  = 32'h0000_00AA;
    localparam logic [DATA_W-1:0] KEY_SECOND = 32'h0000_0055;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_RELOAD = 2'd1,
        REG_FEED   = 2'd2,
        REG_COUNT  = 2'd3
    } reg_addr_e;

    // Control register bit positions
    localparam int B_ARM  = 0;
    localparam int B_RSEL = 1;
    localparam int B_IRQ  = 2;
    localparam int B_WDF  = 3;
    localparam int B_RUN  = 4;

    typedef enum logic {
        FEED_IDLE = 1'b0,
        FEED_HALF = 1'b1
    } feed_state_e;

    typedef struct packed {
        logic arm;
        logic rsel;
        logic run;
        logic irq;
        logic wdf;
    } ctrl_state_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_state_t s);
        logic [DATA_W-1:0] v;
        v         = '0;
        v[B_ARM]  = s.arm;
        v[B_RSEL] = s.rsel;
        v[B_IRQ]  = s.irq;
        v[B_WDF]  = s.wdf;
        v[B_RUN]  = s.run;
        return v;
    endfunction

endpackage

// File: rtl/wdt_feed_seq.sv
module wdt_feed_seq
    import wdt_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              feed_ok_o,
    output logic              feed_bad_o
);

    feed_state_e st_q, st_d;
    logic        feed_wr;

    always_comb begin
        feed_wr    = sel_i && wr_i && (reg_addr_e'(addr_i) == REG_FEED);
        st_d       = st_q;
        feed_ok_o  = 1'b0;
        feed_bad_o = 1'b0;
        if (sel_i) begin
            if (st_q == FEED_HALF) begin
                // any access closes the pair, good or bad
                st_d = FEED_IDLE;
                if (feed_wr && wdata_i == KEY_SECOND) feed_ok_o  = 1'b1;
                else                                  feed_bad_o = 1'b1;
            end else if (feed_wr) begin
                if (wdata_i == KEY_FIRST) st_d       = FEED_HALF;
                else                      feed_bad_o = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= FEED_IDLE;
        else       st_q <= st_d;
    end

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
    parameter int CNT_W   = 32,
    parameter int PRE_DIV = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic             run_i,
    input  logic             halt_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);

    localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic             active, tick;

    always_comb begin
        active   = run_i && !halt_i;
        tick     = active && (pre_q == PRE_LAST);
        expire_o = tick && (cnt_q == '0);
        count_o  = cnt_q;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (load_i) begin
            pre_q <= '0;
            cnt_q <= reload_i;
        end else if (active) begin
            pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
            if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              ctrl_we_i,
    input  logic [DATA_W-1:0] ctrl_wdata_i,
    input  logic              feed_ok_i,
    input  logic              feed_bad_i,
    input  logic              expire_i,
    output ctrl_state_t       st_o,
    output logic              load_o,
    output logic              trip_o,
    output logic              rst_req_o
);

    ctrl_state_t st_q, st_d;
    logic        req_q;

    always_comb begin
        trip_o = expire_i || (feed_bad_i && st_q.run);
        load_o = feed_ok_i && st_q.arm;
        st_d   = st_q;
        if (ctrl_we_i) begin
            st_d.arm  = st_q.arm  | ctrl_wdata_i[B_ARM];
            st_d.rsel = st_q.rsel | ctrl_wdata_i[B_RSEL];
            if (ctrl_wdata_i[B_IRQ]) st_d.irq = 1'b0;
            if (ctrl_wdata_i[B_WDF]) st_d.wdf = 1'b0;
        end
        if (load_o) st_d.run = 1'b1;
        // the watchdog event outranks every software action
        if (trip_o) begin
            st_d.arm  = 1'b0;
            st_d.rsel = 1'b0;
            st_d.run  = 1'b0;
            if (st_q.rsel) st_d.wdf = 1'b1;
            else           st_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q  <= '0;
            req_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            req_q <= trip_o && st_q.rsel;
        end
    end

    assign st_o      = st_q;
    assign rst_req_o = req_q;

endmodule

// File: rtl/wdt_sentinel.sv
module wdt_sentinel
    import wdt_pkg::*;
#(
    parameter int                CNT_W      = 32,
    parameter int                PRE_DIV    = 4,
    parameter logic [CNT_W-1:0]  RELOAD_RST = 32'h0000_00FF
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              dbg_halt_i,
    output logic              rst_req_o,
    output logic              irq_o
);

    ctrl_state_t      ctrl_st;
    logic [CNT_W-1:0] reload_q, count;
    logic             feed_ok, feed_bad, expire, load, trip, ctrl_we;
    reg_addr_e        addr;

    assign addr    = reg_addr_e'(bus_addr_i);
    assign ctrl_we = bus_sel_i && bus_wr_i && (addr == REG_CTRL);

    always_ff @(posedge clk_i) begin
        if (rst_i)
            reload_q <= RELOAD_RST;
        else if (bus_sel_i && bus_wr_i && addr == REG_RELOAD)
            reload_q <= bus_wdata_i[CNT_W-1:0];
    end

    wdt_feed_seq u_feed (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .sel_i      (bus_sel_i),
        .wr_i       (bus_wr_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .feed_ok_o  (feed_ok),
        .feed_bad_o (feed_bad)
    );

    wdt_countdown #(.CNT_W(CNT_W), .PRE_DIV(PRE_DIV)) u_cnt (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .load_i   (load),
        .reload_i (reload_q),
        .run_i    (ctrl_st.run),
        .halt_i   (dbg_halt_i),
        .count_o  (count),
        .expire_o (expire)
    );

    wdt_ctrl u_ctrl (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .ctrl_we_i    (ctrl_we),
        .ctrl_wdata_i (bus_wdata_i),
        .feed_ok_i    (feed_ok),
        .feed_bad_i   (feed_bad),
        .expire_i     (expire),
        .st_o         (ctrl_st),
        .load_o       (load),
        .trip_o       (trip),
        .rst_req_o    (rst_req_o)
    );

    assign irq_o = ctrl_st.irq;

    always_comb begin
        bus_rdata_o = '0;
        if (bus_sel_i && !bus_wr_i) begin
            case (addr)
                REG_CTRL:   bus_rdata_o = pack_ctrl(ctrl_st);
                REG_RELOAD: bus_rdata_o = DATA_W'(reload_q);
                REG_COUNT:  bus_rdata_o = DATA_W'(count);
                default:    bus_rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/wdt_sentinel_chk.sv
module wdt_sentinel_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             bus_sel_i,
    input logic             dbg_halt_i,
    input logic             rst_req_o,
    input logic             irq_o,
    input logic             arm,
    input logic             rsel,
    input logic             run,
    input logic             wdf,
    input logic             trip,
    input logic             feed_ok,
    input logic             feed_bad,
    input logic [CNT_W-1:0] count
);

    // R6
    rst_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rst_req_o |=> !rst_req_o);

    // R6
    rst_mode_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rst_req_o |-> $past(rsel));

    // R7
    irq_mode_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(irq_o) |-> !$past(rsel));

    // R2
    arm_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (arm && !trip) |=> arm);

    // R2
    rsel_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (rsel && !trip) |=> rsel);

    // R10
    halt_freeze_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (dbg_halt_i && !bus_sel_i) |=> $stable(count));

    // R3
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!run && !bus_sel_i) |=> $stable(count));

    // R4
    feed_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(feed_ok && feed_bad));

    // R11
    wdf_source_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(wdf) |-> rst_req_o);

endmodule

bind wdt_sentinel wdt_sentinel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .bus_sel_i  (bus_sel_i),
    .dbg_halt_i (dbg_halt_i),
    .rst_req_o  (rst_req_o),
    .irq_o      (irq_o),
    .arm        (ctrl_st.arm),
    .rsel       (ctrl_st.rsel),
    .run        (ctrl_st.run),
    .wdf        (ctrl_st.wdf),
    .trip       (trip),
    .feed_ok    (feed_ok),
    .feed_bad   (feed_bad),
    .count      (count)
);

// File: tb/wdt_sentinel_tb_top.sv
`timescale 1ns/1ps
module wdt_sentinel_tb_top;

    localparam logic [31:0] RELOAD_RST = 32'h0000_00FF;

    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic        bus_sel_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic [1:0]  bus_addr_i = 2'd0;
    logic [31:0] bus_wdata_i = 32'd0;
    logic [31:0] bus_rdata_o;
    logic        dbg_halt_i = 1'b0;
    logic        rst_req_o;
    logic        irq_o;

    int checks = 0;
    int fails = 0;
    int pulses = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk_i = ~clk_i;

    wdt_sentinel #(.RELOAD_RST(RELOAD_RST)) dut_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .bus_sel_i   (bus_sel_i),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .dbg_halt_i  (dbg_halt_i),
        .rst_req_o   (rst_req_o),
        .irq_o       (irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit        m_arm, m_rsel, m_run, m_irq, m_wdf, m_half, m_req;
    int        m_pre;
    bit [31:0] m_cnt, m_reload;

    function automatic bit [31:0] m_rdata();
        bit [31:0] v = 0;
        if (bus_sel_i && !bus_wr_i) begin
            case (bus_addr_i)
                2'd0: v = {27'd0, m_run, m_wdf, m_irq, m_rsel, m_arm};
                2'd1: v = m_reload;
                2'd3: v = m_cnt;
                default: v = 0;
            endcase
        end
        return v;
    endfunction

    always @(posedge clk_i) begin
        bit c_rst, c_sel, c_wr, c_halt, ok, bad, trip, fw, ld;
        bit [1:0]  c_addr;
        bit [31:0] c_wd;
        c_rst = rst_i; c_sel = bus_sel_i; c_wr = bus_wr_i; c_halt = dbg_halt_i;
        c_addr = bus_addr_i; c_wd = bus_wdata_i;
        #1;
        cycles++;
        if (c_rst) begin
            m_arm = 0; m_rsel = 0; m_run = 0; m_irq = 0; m_wdf = 0; m_half = 0;
            m_req = 0; m_pre = 0; m_cnt = 0; m_reload = RELOAD_RST;
        end else begin
            ok = 0; bad = 0;
            fw = c_sel && c_wr && c_addr == 2'd2;
            if (c_sel) begin
                if (m_half) begin
                    if (fw && c_wd == 32'h55) ok = 1; else bad = 1;
                    m_half = 0;
                end else if (fw) begin
                    if (c_wd == 32'hAA) m_half = 1; else bad = 1;
                end
            end
            trip = (m_run && !c_halt && m_pre == 3 && m_cnt == 0) || (bad && m_run);
            ld = ok && m_arm;
            m_req = trip && m_rsel;
            if (ld) begin
                m_cnt = m_reload; m_pre = 0;
            end else if (m_run && !c_halt) begin
                if (m_pre == 3) begin
                    m_pre = 0;
                    if (m_cnt != 0) m_cnt = m_cnt - 1;
                end else m_pre = m_pre + 1;
            end
            if (c_sel && c_wr && c_addr == 2'd0) begin
                if (c_wd[0]) m_arm = 1;
                if (c_wd[1]) m_rsel = 1;
                if (c_wd[2]) m_irq = 0;
                if (c_wd[3]) m_wdf = 0;
            end
            if (c_sel && c_wr && c_addr == 2'd1) m_reload = c_wd;
            if (ld) m_run = 1;
            if (trip) begin
                if (m_rsel) m_wdf = 1; else m_irq = 1;
                m_arm = 0; m_rsel = 0; m_run = 0;
            end
        end
        if (rst_req_o) pulses++;
        if (!done) begin
            chk("R6 rst_req_o model", {31'd0, rst_req_o}, {31'd0, m_req});
            chk("R7 irq_o model", {31'd0, irq_o}, {31'd0, m_irq});
            chk("R5 bus_rdata_o model", bus_rdata_o, m_rdata());
        end
        if (cycles > 20000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_sel_i = 1; bus_wr_i = 1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk_i);
        bus_sel_i = 0; bus_wr_i = 0; bus_wdata_i = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_sel_i = 1; bus_wr_i = 0; bus_addr_i = a;
        #1 d = bus_rdata_o;
        @(negedge clk_i);
        bus_sel_i = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk_i);
    endtask

    task automatic feed();
        wr(2'd2, 32'hAA);
        wr(2'd2, 32'h55);
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk_i);
        rst_i = 0;
        // R1 reset state
        rd(2'd0, d); chk("R1 ctrl after reset", d, 32'h0);
        rd(2'd1, d); chk("R1 reload after reset", d, RELOAD_RST);
        rd(2'd3, d); chk("R1 count after reset", d, 32'h0);
        chk("R1 outputs low", {30'd0, rst_req_o, irq_o}, 32'h0);
        // R3 feed while disabled does nothing
        feed();
        rd(2'd3, d); chk("R3 count unchanged when disabled", d, 32'h0);
        wr(2'd1, 32'd5);
        wr(2'd0, 32'h1);
        idle(10);
        rd(2'd3, d); chk("R3 armed but idle before feed", d, 32'h0);
        // R2 sticky enable
        wr(2'd0, 32'h0);
        rd(2'd0, d); chk("R2 enable stays set", d, 32'h1);
        // R4 valid feed loads
        feed();
        rd(2'd3, d); chk("R4 count loaded by feed", d, 32'd5);
        // R5 decrement every 4 cycles
        idle(3);
        rd(2'd3, d); chk("R5 first decrement", d, 32'd4);
        idle(3);
        rd(2'd3, d); chk("R5 second decrement", d, 32'd3);
        // R10 debug halt freezes count and prescaler
        dbg_halt_i = 1;
        idle(20);
        rd(2'd3, d); chk("R10 count frozen", d, 32'd3);
        dbg_halt_i = 0;
        idle(3);
        rd(2'd3, d); chk("R10 prescaler phase kept", d, 32'd2);
        // R7 timeout in interrupt mode
        idle(40);
        chk("R7 irq_o raised", {31'd0, irq_o}, 32'd1);
        rd(2'd0, d); chk("R7 ctrl after irq timeout", d, 32'h4);
        wr(2'd0, 32'h4);
        rd(2'd0, d); chk("R7 irq flag cleared", d, 32'h0);
        chk("R7 irq_o dropped", {31'd0, irq_o}, 32'd0);
        // R9 bad feeds while not running
        wr(2'd2, 32'h33);
        wr(2'd2, 32'hAA);
        rd(2'd0, d); chk("R9 no effect when idle", d, 32'h0);
        chk("R9 irq_o still low", {30'd0, rst_req_o, irq_o}, 32'h0);
        // R6 timeout in reset mode
        wr(2'd1, 32'd2);
        wr(2'd0, 32'h3);
        wr(2'd0, 32'h0);
        rd(2'd0, d); chk("R2 both sticky bits held", d, 32'h3);
        feed();
        idle(40);
        chk("R6 one reset pulse", pulses, 32'd1);
        rd(2'd0, d); chk("R6 ctrl after reset timeout", d, 32'h8);
        chk("R6 irq_o low in reset mode", {31'd0, irq_o}, 32'd0);
        // R11 clear flag by software
        wr(2'd0, 32'h8);
        rd(2'd0, d); chk("R11 flag cleared by write", d, 32'h0);
        // R8 broken pair while running, reset mode
        wr(2'd1, 32'd100);
        wr(2'd0, 32'h3);
        feed();
        wr(2'd2, 32'hAA);
        wr(2'd1, 32'd100);
        idle(2);
        chk("R8 broken pair gives reset pulse", pulses, 32'd2);
        rd(2'd0, d); chk("R8 ctrl after fault", d, 32'h8);
        // R11 hardware reset clears flag
        rst_i = 1;
        idle(3);
        rst_i = 0;
        rd(2'd0, d); chk("R11 flag cleared by hw reset", d, 32'h0);
        // R8 wrong value while running, interrupt mode
        wr(2'd1, 32'd50);
        wr(2'd0, 32'h1);
        feed();
        wr(2'd2, 32'h55);
        idle(1);
        chk("R8 wrong key raises irq", {31'd0, irq_o}, 32'd1);
        rd(2'd0, d); chk("R8 ctrl after wrong key", d, 32'h4);
        idle(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule